// File: doc/BRIEF.md
# Dual-Integrator Conversion Timing Generator

This block produces the timing a dual-channel charge-digitizing converter needs. Each channel of such a converter has two integrators, and one integrates while the other is digitized and cleared. A level signal, called CONV here, selects which side integrates: every time it changes level the two sides swap roles. The block halves the system clock to make the converter clock. It holds CONV at each level for a programmed number of converter clock periods, in steps of one converter clock period. It drives a static three-bit gain word and raises a status flag when the programmed integration time is too short for the converter to finish digitizing both channels before the sides swap.

CONV can come from three places: the internal period timer, the external input wired straight through, or the external input taken through a two-flop synchronizer on the system clock. Settings arrive through a single-cycle write port. The period count and the minimum-digitize count are held in shadow registers. A new value goes into force only at the next edge of the selected CONV source, so a period already running is never cut short.

Top module: `conv_timing_gen`

## Requirements
- R1: While rst_ni is low, conv_o, cclk_o and noncont_o are 0 and gain_o is DEF_GAIN (0). After reset, the in-force period is DEF_PERIOD, the in-force minimum is DEF_MIN and the source is internal.
- R2: cclk_o changes level on every rising edge of clk_i. It is 1 after the first edge following reset release and 0 after the second, so its period is two system clocks.
- R3: In internal mode, conv_o changes level every 2*P system clocks, where P is the in-force period count. A count of 0 behaves as 1. The first change after reset release comes at edge 2*DEF_PERIOD.
- R4: In internal mode, a period count written during an interval does not alter that interval. It governs the interval that starts at the next conv_o change.
- R5: In raw-external mode, conv_o follows ext_conv_i with no register in the path.
- R6: In resynchronized mode, conv_o equals the ext_conv_i value sampled two rising edges earlier.
- R7: In resynchronized mode, written period and minimum counts go into force on the edge after the synchronized external signal changes. In raw-external mode they go into force on the edge after the write.
- R8: noncont_o is 1 exactly when the in-force period count is below the in-force minimum-digitize count. In internal mode it changes only together with a conv_o change.
- R9: gain_o holds the low three bits of the last write to address 3 and is unaffected by writes to other addresses.
- R10: Write addresses are: 0 period count, 1 minimum-digitize count, 2 source select, 3 gain. The source select is wr_data_i[1:0]: 0 internal, 1 raw external, 2 resynchronized external, 3 internal. A write takes effect at the clock edge on which wr_en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| ext_conv_i | input | 1 | External CONV input |
| conv_o | output | 1 | Integrator side select to the converter |
| cclk_o | output | 1 | Converter clock, system clock halved |
| gain_o | output | 3 | Static gain word |
| noncont_o | output | 1 | Integration period below the digitize minimum |

## Verification
The bench builds the block with DEF_PERIOD=20, DEF_MIN=8, CNT_W=16 and SYNC_STAGES=2. The short default period puts the first CONV change 40 cycles after reset, so the reset timing is checked exactly rather than only the steady-state intervals. Small programmed counts (0, 10, 30) make it affordable to check the divide-by-zero floor, the deferred shadow load across a full interval, and the noncontinuous flag switching in both directions in every source mode. With two synchronizer stages the resynchronized latency is a fixed two edges, which the bench checks edge by edge.

// File: rtl/conv_timing_pkg.sv
package conv_timing_pkg;
  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_RAW  = 2'd1,
    SRC_SYNC = 2'd2,
    SRC_INT2 = 2'd3
  } conv_src_e;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_MIN    = 2'd1;
  localparam logic [1:0] ADDR_SRC    = 2'd2;
  localparam logic [1:0] ADDR_GAIN   = 2'd3;

  localparam int GAIN_W = 3;
endpackage

// File: rtl/conv_regs.sv
module conv_regs
  import conv_timing_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 5000,
  parameter int DEF_MIN    = 2400,
  parameter int DEF_GAIN   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  min_o,
  output conv_src_e         src_o,
  output logic [GAIN_W-1:0] gain_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= CNT_W'(DEF_PERIOD);
      min_o    <= CNT_W'(DEF_MIN);
      src_o    <= SRC_INT;
      gain_o   <= GAIN_W'(DEF_GAIN);
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_PERIOD: period_o <= wr_data_i;
        ADDR_MIN:    min_o    <= wr_data_i;
        ADDR_SRC:    src_o    <= conv_src_e'(wr_data_i[1:0]);
        default:     gain_o   <= wr_data_i[GAIN_W-1:0];
      endcase
    end
  end

  AST_GAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_GAIN) |=> $stable(gain_o)); // R9
endmodule

// File: rtl/cclk_div.sv
module cclk_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cclk_o,
  output logic tick_o
);
  logic cclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cclk_q <= 1'b0;
    else         cclk_q <= ~cclk_q;
  end

  assign cclk_o = cclk_q;
  // one enable per converter clock period, on the edge where cclk falls
  assign tick_o = cclk_q;

  AST_CCLK_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cclk_q != $past(cclk_q))); // R2
endmodule

// File: rtl/ext_conv_sync.sv
module ext_conv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[i] <= 1'b0;
        else         sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign sync_o = sh_q[STAGES-1];
  // the extra stage serves only edge detection on the synchronized signal
  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/conv_period_timer.sv
module conv_period_timer #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 5000,
  parameter int DEF_MIN    = 2400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             int_load_i,
  input  logic             ext_load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             conv_o,
  output logic             noncont_o
);
  logic [CNT_W-1:0] cnt_q, act_per_q, act_min_q;
  logic             conv_q;
  logic             last, wrap, load;

  // >= keeps a shadow reload below the running count safe
  assign last = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, act_per_q};
  assign wrap = tick_i && last;
  assign load = int_load_i ? wrap : ext_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      conv_q    <= 1'b0;
      act_per_q <= CNT_W'(DEF_PERIOD);
      act_min_q <= CNT_W'(DEF_MIN);
    end else begin
      if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (wrap)   conv_q <= ~conv_q;
      if (load) begin
        act_per_q <= period_i;
        act_min_q <= min_i;
      end
    end
  end

  assign conv_o    = conv_q;
  assign noncont_o = act_per_q < act_min_q;

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(conv_q)); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_load_i && !tick_i) |=> ($stable(act_per_q) && $stable(act_min_q))); // R4
endmodule

// File: rtl/conv_timing_gen.sv
module conv_timing_gen
  import conv_timing_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEF_PERIOD  = 5000,
  parameter int DEF_MIN     = 2400,
  parameter int DEF_GAIN    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ext_conv_i,
  output logic             conv_o,
  output logic             cclk_o,
  output logic [2:0]       gain_o,
  output logic             noncont_o
);
  logic [CNT_W-1:0] period, min_cnt;
  conv_src_e        src;
  logic             tick, conv_int, ext_sync, ext_edge;
  logic             src_int, ext_load;

  conv_regs #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_MIN(DEF_MIN), .DEF_GAIN(DEF_GAIN)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period), .min_o(min_cnt), .src_o(src), .gain_o(gain_o)
  );

  cclk_div u_div (.clk_i, .rst_ni, .cclk_o(cclk_o), .tick_o(tick));

  ext_conv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(ext_conv_i), .sync_o(ext_sync), .edge_o(ext_edge)
  );

  assign src_int  = (src == SRC_INT) || (src == SRC_INT2);
  // raw input has no edge visible in this domain: load at once
  assign ext_load = (src == SRC_SYNC) ? ext_edge : 1'b1;

  conv_period_timer #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_MIN(DEF_MIN)
  ) u_timer (
    .clk_i, .rst_ni, .tick_i(tick), .int_load_i(src_int), .ext_load_i(ext_load),
    .period_i(period), .min_i(min_cnt), .conv_o(conv_int), .noncont_o(noncont_o)
  );

  always_comb begin
    case (src)
      SRC_RAW:  conv_o = ext_conv_i;
      SRC_SYNC: conv_o = ext_sync;
      default:  conv_o = conv_int;
    endcase
  end

  // cycles since reset release, saturating; bounds $past windows below
  logic [1:0] rst_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rst_age_q <= '0;
    else if (rst_age_q != 2'd3) rst_age_q <= rst_age_q + 1'b1;
  end

  if (SYNC_STAGES == 2) begin : g_lat_chk
    AST_RESYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_age_q == 2'd3 && src == SRC_SYNC) |-> (conv_o == $past(ext_conv_i, 2))); // R6
  end

  AST_NONCONT_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_int && $past(src_int) && rst_age_q != 2'd0 && (noncont_o != $past(noncont_o)))
      |-> (conv_o != $past(conv_o))); // R8
endmodule

// File: tb/tb_conv_timing_gen.sv
`timescale 1ns/1ps
module tb_conv_timing_gen;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             ext_conv_i = 1'b0;
  logic             conv_o, cclk_o, noncont_o;
  logic [2:0]       gain_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  conv_timing_gen #(
    .CNT_W(CNT_W), .DEF_PERIOD(20), .DEF_MIN(8), .DEF_GAIN(0), .SYNC_STAGES(2)
  ) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ext_conv_i, .conv_o, .cclk_o, .gain_o, .noncont_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = CNT_W'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_toggle(output int n);
    logic prev;
    prev = conv_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (conv_o == prev && n < 2000);
  endtask

  task automatic t_reset;
    int n;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(conv_o == 0 && noncont_o == 0, "R1 conv/noncont in reset", {conv_o, noncont_o}, 0);
    chk(cclk_o == 0, "R1 cclk in reset", cclk_o, 0);
    chk(gain_o == 0, "R1 gain in reset", gain_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cclk_o == 1, "R2 cclk after edge 1", cclk_o, 1);
    @(negedge clk);
    chk(cclk_o == 0, "R2 cclk after edge 2", cclk_o, 0);
    wait_toggle(n);
    chk(n == 38, "R3 first toggle at edge 40", n + 2, 40);
    chk(conv_o == 1, "R3 conv level after first toggle", conv_o, 1);
  endtask

  task automatic t_period;
    int n;
    wr(2'd0, 10);
    wait_toggle(n);
    wait_toggle(n);
    chk(n == 20, "R3 interval for P=10", n, 20);
    wr(2'd0, 30);
    wait_toggle(n);
    chk(n == 19, "R4 running interval not cut", n + 1, 20);
    wait_toggle(n);
    chk(n == 60, "R4 new period after edge", n, 60);
    wr(2'd0, 0);
    wait_toggle(n);
    wait_toggle(n);
    chk(n == 2, "R3 zero period acts as one", n, 2);
    wr(2'd0, 10);
    wait_toggle(n);
    wait_toggle(n);
    chk(n == 20, "R3 back to P=10", n, 20);
  endtask

  task automatic t_noncont;
    int n;
    wr(2'd1, 15);
    chk(noncont_o == 0, "R8 min not in force before edge", noncont_o, 0);
    wait_toggle(n);
    @(negedge clk);
    chk(noncont_o == 1, "R8 period below min", noncont_o, 1);
    wr(2'd1, 5);
    wait_toggle(n);
    @(negedge clk);
    chk(noncont_o == 0, "R8 period above min", noncont_o, 0);
  endtask

  task automatic t_raw;
    wr(2'd2, 1);
    ext_conv_i = 1'b1; #1;
    chk(conv_o == 1, "R5 raw follows high", conv_o, 1);
    ext_conv_i = 1'b0; #1;
    chk(conv_o == 0, "R5 raw follows low", conv_o, 0);
    @(negedge clk);
    wr(2'd1, 100);
    repeat (2) @(negedge clk);
    chk(noncont_o == 1, "R7 raw mode loads at once", noncont_o, 1);
    wr(2'd1, 5);
    repeat (2) @(negedge clk);
    chk(noncont_o == 0, "R7 raw mode reload", noncont_o, 0);
  endtask

  task automatic t_resync;
    wr(2'd2, 2);
    repeat (3) @(negedge clk);
    ext_conv_i = 1'b1;
    @(negedge clk);
    chk(conv_o == 0, "R6 one edge later still old", conv_o, 0);
    @(negedge clk);
    chk(conv_o == 1, "R6 two edges later new", conv_o, 1);
    repeat (2) @(negedge clk);
    wr(2'd1, 100);
    repeat (4) @(negedge clk);
    chk(noncont_o == 0, "R7 resync waits for edge", noncont_o, 0);
    ext_conv_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(noncont_o == 1, "R7 resync loads after edge", noncont_o, 1);
    chk(conv_o == 0, "R6 follows falling input", conv_o, 0);
    wr(2'd1, 5);
    ext_conv_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(noncont_o == 0, "R7 resync reload", noncont_o, 0);
  endtask

  task automatic t_src_alt;
    int n;
    wr(2'd2, 3);
    wait_toggle(n);
    wait_toggle(n);
    wait_toggle(n);
    chk(n == 20, "R10 select 3 runs internal", n, 20);
    ext_conv_i = 1'b0;
    wr(2'd2, 0);
    wait_toggle(n);
    wait_toggle(n);
    chk(n == 20, "R10 select 0 runs internal", n, 20);
  endtask

  task automatic t_gain;
    wr(2'd3, 5);
    chk(gain_o == 5, "R9 gain write", gain_o, 5);
    wr(2'd0, 10);
    wr(2'd1, 5);
    wr(2'd2, 0);
    chk(gain_o == 5, "R9 other addresses leave gain", gain_o, 5);
    wr(2'd3, 16'h00FA);
    chk(gain_o == 2, "R9 low three bits only", gain_o, 2);
  endtask

  initial begin
    t_reset();
    t_period();
    t_noncont();
    t_raw();
    t_resync();
    t_src_alt();
    t_gain();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule